// File: doc/BRIEF.md
# Event-Table PWM Generator

This block produces two raw pulse-width-modulated signals from a single up-counting time base. A counter climbs from zero to a programmable top value and then returns to zero. On the way it raises three kinds of event: reaching the top value, matching compare value A, and matching compare value B. Each output has its own small table that gives every event a two-bit action code. The code can leave the output alone, drive it low, drive it high, or invert it. The edges of the waveform therefore come from the table and not from a fixed counter-below-threshold test. Any of the usual shapes can be programmed: edge-aligned duty cycles, fixed-frequency square waves, or outputs that are driven only by compare matches.

The top value and both compare values are taken into internal shadow registers only when the counter returns to zero. Software can change them at any time without producing a cut-short or stretched period. The action codes take effect immediately. Both outputs are registered and are intended to drive a later dead-band stage.

Top module: `pwm_evtab_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both outputs are low and the counter is at zero.
- R2: With a loaded top value P, the counter visits 0, 1, …, P and then returns to 0, so one period lasts P+1 clock cycles.
- R3: The action codes are 00 = leave unchanged, 01 = drive low, 10 = drive high and 11 = invert. An event whose code is 00 has no effect on the output.
- R4: An output's response to an event appears on the clock edge that ends the cycle in which the counter shows the event's count. If output A is driven high at the top event and low at compare A (value C), it is high for exactly C+1 cycles of every period.
- R5: Output B follows the same rule using its own table. If it is driven high at the top event and low at compare B (value D), it is high for exactly D+1 cycles of every period.
- R6: When the top event and a compare event fall on the same count and both carry a non-00 code, the compare event's action is applied.
- R7: When compare A and compare B match on the same count and both carry a non-00 code, the compare B action is applied. Events with code 00 never outrank lower-ranked events.
- R8: A loaded top value of 0 holds the counter at zero, so the top event occurs on every cycle.
- R9: The top value and the two compare values are sampled only on the edge where the counter returns to zero. A change made in the middle of a period does not affect that period.
- R10: A compare value above the loaded top value never produces a compare event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the time base advances once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_val_i | input | CNT_W | Top count of the time base; shadowed at wrap |
| cmp_a_i | input | CNT_W | Compare value A; shadowed at wrap |
| cmp_b_i | input | CNT_W | Compare value B; shadowed at wrap |
| a_top_act_i | input | 2 | Action applied to output A on the top event |
| a_cmpa_act_i | input | 2 | Action applied to output A on a compare A match |
| a_cmpb_act_i | input | 2 | Action applied to output A on a compare B match |
| b_top_act_i | input | 2 | Action applied to output B on the top event |
| b_cmpa_act_i | input | 2 | Action applied to output B on a compare A match |
| b_cmpb_act_i | input | 2 | Action applied to output B on a compare B match |
| pwm_a_o | output | 1 | Raw PWM output A |
| pwm_b_o | output | 1 | Raw PWM output B |

## Verification
The bench places a compare value on the same count as the top event, and then makes compare A and compare B match together. A design that ranks the events the wrong way would hold the output high where it should stay low. A top value of zero is loaded next. This shows whether the counter is held and the top event fires on every cycle, so an inverting output must flip each clock, and a counter that runs away past zero would produce a slow square wave instead. A compare value is changed right after a period starts. The high run of that period must keep its old length, and a design without shadowing would stretch it at once. An out-of-range compare value and 00-coded events are also used: a design that lets them act would change an output that should stay constant.

// File: rtl/pwm_evtab_pkg.sv
package pwm_evtab_pkg;

   // Two-bit action applied to an output when its event fires
   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } edge_act_e;

   function automatic logic act_apply(input logic cur, input edge_act_e act);
      logic nxt;
      case (act)
         ACT_LOW:  nxt = 1'b0;
         ACT_HIGH: nxt = 1'b1;
         ACT_FLIP: nxt = ~cur;
         default:  nxt = cur;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_CMP = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CNT_W-1:0]            top_in,
   input  logic [N_CMP-1:0][CNT_W-1:0] cmp_in,
   output logic [CNT_W-1:0]            cnt_q,
   output logic [CNT_W-1:0]            top_q,
   output logic [N_CMP-1:0][CNT_W-1:0] cmp_q
);

   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pwm_timebase: CNT_W must lie in 2..32");
   end
   if (N_CMP < 1) begin : g_bad_cmp
      $error("pwm_timebase: N_CMP must be at least 1");
   end

   logic at_top;
   assign at_top = (cnt_q == top_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         top_q <= '0;
      end else if (at_top) begin
         cnt_q <= '0;
         top_q <= top_in;
      end else begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   for (genvar k = 0; k < N_CMP; k++) begin : g_cmp_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cmp_q[k] <= '0;
         else if (at_top) cmp_q[k] <= cmp_in[k];
      end
   end

   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= top_q);
   // R2
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == top_q) |=> (cnt_q == '0));
   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != top_q) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> ($stable(top_q) && $stable(cmp_q)));

endmodule

// File: rtl/pwm_evt_match.sv
module pwm_evt_match #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_CMP = 2
) (
   input  logic [CNT_W-1:0]            cnt,
   input  logic [CNT_W-1:0]            top,
   input  logic [N_CMP-1:0][CNT_W-1:0] cmp,
   output logic                        top_hit,
   output logic [N_CMP-1:0]            cmp_hit
);

   assign top_hit = (cnt == top);

   for (genvar k = 0; k < N_CMP; k++) begin : g_match
      assign cmp_hit[k] = (cnt == cmp[k]);
   end

endmodule

// File: rtl/pwm_act_chan.sv
module pwm_act_chan
   import pwm_evtab_pkg::*;
#(
   parameter int unsigned N_EVT = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_EVT-1:0]      hit,
   input  logic [N_EVT-1:0][1:0] code,
   output logic                  out_q
);

   if (N_EVT < 1) begin : g_bad_evt
      $error("pwm_act_chan: N_EVT must be at least 1");
   end

   // Higher index ranks higher; code 00 never claims an event
   edge_act_e sel;
   always_comb begin
      sel = ACT_HOLD;
      for (int i = 0; i < N_EVT; i++) begin
         if (hit[i] && (code[i] != 2'b00)) sel = edge_act_e'(code[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= act_apply(out_q, sel);
   end

   // R3
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == ACT_HOLD) |=> $stable(out_q));
   // R3
   flip_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == ACT_FLIP) |=> (out_q != $past(out_q)));
   // R7
   top_rank_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[N_EVT-1] && code[N_EVT-1] == 2'b10) |=> out_q);
   // R7
   top_rank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[N_EVT-1] && code[N_EVT-1] == 2'b01) |=> !out_q);

endmodule

// File: rtl/pwm_evtab_gen.sv
module pwm_evtab_gen #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] top_val_i,
   input  logic [CNT_W-1:0] cmp_a_i,
   input  logic [CNT_W-1:0] cmp_b_i,
   input  logic [1:0]       a_top_act_i,
   input  logic [1:0]       a_cmpa_act_i,
   input  logic [1:0]       a_cmpb_act_i,
   input  logic [1:0]       b_top_act_i,
   input  logic [1:0]       b_cmpa_act_i,
   input  logic [1:0]       b_cmpb_act_i,
   output logic             pwm_a_o,
   output logic             pwm_b_o
);

   localparam int unsigned N_CMP = 2;
   localparam int unsigned N_EVT = N_CMP + 1;
   localparam int unsigned N_CH  = 2;

   logic [CNT_W-1:0]                   cnt, top_sh;
   logic [N_CMP-1:0][CNT_W-1:0]        cmp_raw, cmp_sh;
   logic                               top_hit;
   logic [N_CMP-1:0]                   cmp_hit;
   logic [N_EVT-1:0]                   hits;
   logic [N_CH-1:0][N_EVT-1:0][1:0]    codes;
   logic [N_CH-1:0]                    pwm_q;

   assign cmp_raw  = {cmp_b_i, cmp_a_i};
   // Event rank: [0] top, [1] compare A, [2] compare B
   assign hits     = {cmp_hit, top_hit};
   assign codes[0] = {a_cmpb_act_i, a_cmpa_act_i, a_top_act_i};
   assign codes[1] = {b_cmpb_act_i, b_cmpa_act_i, b_top_act_i};

   pwm_timebase #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_tbase (
      .clk    (clk),
      .rst_n  (rst_n),
      .top_in (top_val_i),
      .cmp_in (cmp_raw),
      .cnt_q  (cnt),
      .top_q  (top_sh),
      .cmp_q  (cmp_sh)
   );

   pwm_evt_match #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_match (
      .cnt     (cnt),
      .top     (top_sh),
      .cmp     (cmp_sh),
      .top_hit (top_hit),
      .cmp_hit (cmp_hit)
   );

   for (genvar g = 0; g < N_CH; g++) begin : g_chan
      pwm_act_chan #(.N_EVT(N_EVT)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (hits),
         .code  (codes[g]),
         .out_q (pwm_q[g])
      );
   end

   assign pwm_a_o = pwm_q[0];
   assign pwm_b_o = pwm_q[1];

   // R1
   reset_low_chk: assert property (@(posedge clk)
      !rst_n |=> (!pwm_a_o && !pwm_b_o));
   // R8
   zero_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (top_sh == '0) |-> (cnt == '0));
   // R10
   cmp_beyond_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_sh[0] > top_sh) |-> !cmp_hit[0]);

endmodule

// File: tb/sim_pwm_evtab_gen.sv
`timescale 1ns/1ps
module sim_pwm_evtab_gen;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] top_v = '0, ca = '0, cb = '0;
   logic [1:0]   a_t = 2'b00, a_a = 2'b00, a_b = 2'b00;
   logic [1:0]   b_t = 2'b00, b_a = 2'b00, b_b = 2'b00;
   logic         pwm_a, pwm_b;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   pwm_evtab_gen #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .top_val_i(top_v), .cmp_a_i(ca), .cmp_b_i(cb),
      .a_top_act_i(a_t), .a_cmpa_act_i(a_a), .a_cmpb_act_i(a_b),
      .b_top_act_i(b_t), .b_cmpa_act_i(b_a), .b_cmpb_act_i(b_b),
      .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
   );

   // Reference process: expected outputs from the requirements
   logic [1:0] exp_q[$];
   logic [W-1:0] m_cnt, m_top, m_ca, m_cb;
   logic m_a, m_b;

   function automatic logic ref_step(input logic cur, input bit ht, input bit ha,
                                     input bit hb, input logic [1:0] ct,
                                     input logic [1:0] cta, input logic [1:0] ctb);
      logic [1:0] act;
      act = 2'b00;
      if (ht && ct  != 2'b00) act = ct;   // lowest rank
      if (ha && cta != 2'b00) act = cta;  // R6
      if (hb && ctb != 2'b00) act = ctb;  // R7
      case (act)
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         2'b11:   return ~cur;
         default: return cur;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_top = '0; m_ca = '0; m_cb = '0; m_a = 1'b0; m_b = 1'b0;
      end else begin
         bit ht, ha, hb;
         ht = (m_cnt == m_top);
         ha = (m_cnt == m_ca);
         hb = (m_cnt == m_cb);
         m_a = ref_step(m_a, ht, ha, hb, a_t, a_a, a_b);
         m_b = ref_step(m_b, ht, ha, hb, b_t, b_a, b_b);
         if (ht) begin
            m_cnt = '0; m_top = top_v; m_ca = ca; m_cb = cb;
         end else begin
            m_cnt = m_cnt + 1'b1;
         end
      end
      exp_q.push_back({m_a, m_b});
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      if (!done && exp_q.size() > 0) begin
         logic [1:0] e;
         e = exp_q.pop_front();
         chk(cur_req, {30'd0, pwm_a, pwm_b}, {30'd0, e}, "scoreboard {a,b}");
      end
   end

   task automatic window(input int n, output int ha, output int hb, output int chg);
      logic prev;
      ha = 0; hb = 0; chg = 0; prev = pwm_a;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ha += int'(pwm_a);
         hb += int'(pwm_b);
         if (pwm_a != prev) chg++;
         prev = pwm_a;
      end
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      int ha, hb, chg, run;
      // R1: reset state
      settle(4);
      chk("R1", int'(pwm_a), 0, "pwm_a in reset");
      chk("R1", int'(pwm_b), 0, "pwm_b in reset");

      // R4 / R5: edge-aligned duty, top 9, compare A 4, compare B 6
      top_v = 16'd9; ca = 16'd4; cb = 16'd6;
      a_t = 2'b10; a_a = 2'b01; a_b = 2'b00;
      b_t = 2'b10; b_a = 2'b00; b_b = 2'b01;
      cur_req = "R1";
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(pwm_a), 0, "pwm_a first cycle after reset");
      cur_req = "R4";
      settle(30);
      window(30, ha, hb, chg);
      chk("R4", ha, 15, "A high cycles in 3 periods");
      chk("R5", hb, 21, "B high cycles in 3 periods");

      // R2 / R3: A inverts on top only, B has all codes 00
      cur_req = "R3";
      a_t = 2'b11; a_a = 2'b00; a_b = 2'b00;
      b_t = 2'b00; b_a = 2'b00; b_b = 2'b00;
      settle(25);
      window(40, ha, hb, chg);
      chk("R2", ha, 20, "A high cycles, invert every P+1");
      chk("R2", chg, 4, "A transitions in 40 cycles");
      chk("R3", (hb == 0 || hb == 40) ? 1 : 0, 1, "B constant with code 00");

      // R6: compare on top count beats the top event
      cur_req = "R6";
      ca = 16'd9; cb = 16'd9;
      a_t = 2'b10; a_a = 2'b01; a_b = 2'b00;
      b_t = 2'b01; b_a = 2'b00; b_b = 2'b10;
      settle(25);
      window(20, ha, hb, chg);
      chk("R6", ha, 0, "A low when compare A beats top");
      chk("R6", hb, 20, "B high when compare B beats top");

      // R7: compare B outranks compare A on the same count
      cur_req = "R7";
      ca = 16'd3; cb = 16'd3;
      a_t = 2'b00; a_a = 2'b10; a_b = 2'b01;
      b_t = 2'b00; b_a = 2'b01; b_b = 2'b10;
      settle(25);
      window(20, ha, hb, chg);
      chk("R7", ha, 0, "A follows compare B low");
      chk("R7", hb, 20, "B follows compare B high");

      // R10: compare beyond top never fires
      cur_req = "R10";
      ca = 16'd15; cb = 16'd20;
      a_t = 2'b10; a_a = 2'b01; a_b = 2'b00;
      b_t = 2'b01; b_a = 2'b00; b_b = 2'b10;
      settle(25);
      window(20, ha, hb, chg);
      chk("R10", ha, 20, "A stays high, compare A out of range");
      chk("R10", hb, 0, "B stays low, compare B out of range");

      // R8: top value 0 holds counter, top event every cycle
      cur_req = "R8";
      top_v = 16'd0; cb = 16'd0;
      a_t = 2'b11; a_a = 2'b00; a_b = 2'b00;
      b_t = 2'b10; b_a = 2'b00; b_b = 2'b01;
      settle(15);
      window(20, ha, hb, chg);
      chk("R8", ha, 10, "A high cycles, inverted each clock");
      chk("R8", chg, 20, "A transitions, one per clock");
      chk("R8", hb, 0, "B held low by compare at zero");

      // R9: mid-period compare change waits for the wrap
      cur_req = "R9";
      top_v = 16'd9; ca = 16'd4; cb = 16'd0;
      a_t = 2'b10; a_a = 2'b01; a_b = 2'b00;
      b_t = 2'b00; b_a = 2'b00; b_b = 2'b00;
      settle(30);
      while (pwm_a) @(negedge clk);
      while (!pwm_a) @(negedge clk);
      ca = 16'd8;
      run = 1;
      @(negedge clk);
      while (pwm_a) begin run++; @(negedge clk); end
      chk("R9", run, 5, "high run of period in progress");
      while (!pwm_a) @(negedge clk);
      run = 1;
      @(negedge clk);
      while (pwm_a) begin run++; @(negedge clk); end
      chk("R9", run, 9, "high run after wrap");

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule